// File: doc/BRIEF.md
# USB Root Port Status and Control Register

This block holds the status and control state of one root port of a USB host controller. Software reaches it over a simple 32-bit register bus that has a write strobe, a read strobe and a registered read return. There are two word addresses. The first is the status/control word: connect flag, enable flag, reset bit, link-state code, power bit and a sticky connect-change flag. The second is a power-management word that holds two link-idle timeout bytes and one flag bit.

A small state machine inside the block tracks the port through five states: Disconnected, Polling, Enabled, Disabled and Reset. Event inputs from the link layer drive it: the live attach level, a fault pulse, reset-done and reset-failed pulses, and a link-training-done pulse. A parameter selects the port flavour. A USB3-style port goes to Polling on attach and enables itself when training succeeds. A USB2-style port goes to Disabled on attach and can only be enabled by a port reset.

The enable flag is never set by a software write. Software can only request a disable. The enable flag rises only when the state machine completes a reset or link training. Reset entry, detach, a fault or power-off forces it low.

Top module: `usb_port_ctl`

## Requirements
- R1: After reset, the status word (offset 0x0) reads 0x000000A0, which is link code 5 with every other bit 0, and the power-management word (offset 0x4) reads 0.
- R2: In the Enabled state, a status write with bit 1 = 1 makes bit 1 read 0 and the link code read 4 (Disabled) from the next clock on. A write with bit 1 = 0 changes nothing.
- R3: A status write with bit 1 = 1 never sets the enable flag. When the port is not enabled, the flag stays 0.
- R4: A fault pulse, or the attach input going low, clears the enable flag. A fault leaves link code 4. A detach leaves link code 5 and clears bit 0.
- R5: A status write with bit 4 = 1 on a connected, powered port enters Reset: bit 4 reads 1, the link code reads 3 and bit 1 reads 0. A reset-done pulse clears bit 4 and sets bit 1 with link code 0. A reset-failed pulse clears bit 4 and leaves bit 1 at 0 with link code 4.
- R6: On a USB2-style port, an attach leads to Disabled (link code 4). Training pulses and link-state writes do not enable it or move it; only a port reset does.
- R7: On a USB3-style port, an attach leads to Polling (link code 7), and a training-done pulse moves it to Enabled (link code 0, bit 1 = 1).
- R8: On a USB3-style port in Disabled, a training pulse has no effect. A status write with bit 16 = 1 and link value 5 in bits 8:5 moves it to Disconnected; while still attached it then returns to Polling.
- R9: With the power bit (bit 9) at 0, bits 0 and 1 read 0 and the link code reads 5.
- R10: Power-management word bits 16:0 are read/write (U1 timeout in 7:0, U2 timeout in 15:8, flag in 16). Bits 31:17 read 0. Status word bits 31:18 read 0.
- R11: A single status write with both bit 1 and bit 4 set performs the reset and ignores the disable request.
- R12: Bit 17 becomes 1 on any change of the attach input. A write of 1 to bit 17 clears it, and a write of 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one clock after a read strobe |
| attach_i | input | 1 | Live device-attached level |
| fault_i | input | 1 | Port fault pulse |
| rst_done_i | input | 1 | Port reset completed successfully |
| rst_fail_i | input | 1 | Port reset failed |
| train_ok_i | input | 1 | Link training completed |

## Verification
The bench builds two instances side by side, one with IS_USB3 = 1 and one with IS_USB3 = 0, and keeps the default 8-bit timeouts. This lets both attach paths be compared under the same bus traffic: the USB3-style port exercises Polling, training-driven enable and the link-value-5 escape from Disabled. The USB2-style instance shows that only a reset can enable its port and that link writes leave it in Disabled. Every expected read word is built from the bit positions in the requirements and matched against the read return in order.

// File: rtl/usbp_pkg.sv
package usbp_pkg;

  localparam int B_CCS  = 0;
  localparam int B_PED  = 1;
  localparam int B_PR   = 4;
  localparam int B_LS   = 5;
  localparam int LS_W   = 4;
  localparam int B_PWR  = 9;
  localparam int B_LWS  = 16;
  localparam int B_CSC  = 17;
  localparam int ST_TOP = 18;

  localparam logic [LS_W-1:0] LS_RXDET = 4'd5;

  typedef enum logic [LS_W-1:0] {
    PS_EN   = 4'd0,
    PS_RST  = 4'd3,
    PS_DIS  = 4'd4,
    PS_DISC = 4'd5,
    PS_POLL = 4'd7
  } pst_e;

  typedef struct packed {
    logic            dis_req;
    logic            rst_req;
    logic            pwr_we;
    logic            pwr_val;
    logic            ls_we;
    logic [LS_W-1:0] ls_val;
    logic            csc_clr;
  } swreq_t;

endpackage

// File: rtl/usbp_regif.sv
module usbp_regif
  import usbp_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int PM_W   = 17,
  parameter int ST_OFS = 0,
  parameter int PM_OFS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output swreq_t            wreq,
  output logic              pm_we,
  input  logic [PM_W-1:0]   pm_q,
  input  logic              ccs,
  input  logic              ped,
  input  logic              prst,
  input  pst_e              st,
  input  logic              pwr,
  input  logic              csc
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] ST_IDX = IDX_W'(ST_OFS / 4);
  localparam logic [IDX_W-1:0] PM_IDX = IDX_W'(PM_OFS / 4);

  logic              aligned;
  logic              sel_st;
  logic              sel_pm;
  logic [DATA_W-1:0] st_word;
  logic [DATA_W-1:0] pm_word;
  logic              unused_wbits;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign sel_st  = aligned && (bus_addr[ADDR_W-1:2] == ST_IDX);
  assign sel_pm  = aligned && (bus_addr[ADDR_W-1:2] == PM_IDX);

  assign unused_wbits = ^bus_wdata[DATA_W-1:ST_TOP];

  always_comb begin
    wreq         = '0;
    if (bus_wr && sel_st) begin
      wreq.dis_req = bus_wdata[B_PED];
      wreq.rst_req = bus_wdata[B_PR];
      wreq.pwr_we  = 1'b1;
      wreq.pwr_val = bus_wdata[B_PWR];
      wreq.ls_we   = bus_wdata[B_LWS];
      wreq.ls_val  = bus_wdata[B_LS +: LS_W];
      wreq.csc_clr = bus_wdata[B_CSC];
    end
  end

  assign pm_we = bus_wr && sel_pm;

  always_comb begin
    st_word                 = '0;
    st_word[B_CCS]          = ccs;
    st_word[B_PED]          = ped;
    st_word[B_PR]           = prst;
    st_word[B_LS +: LS_W]   = st;
    st_word[B_PWR]          = pwr;
    st_word[B_CSC]          = csc;
  end

  assign pm_word = {{(DATA_W-PM_W){1'b0}}, pm_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        if (sel_st)      bus_rdata <= st_word;
        else if (sel_pm) bus_rdata <= pm_word;
        else             bus_rdata <= '0;
      end
    end
  end

endmodule

// File: rtl/usbp_pmw.sv
module usbp_pmw #(
  parameter int DATA_W = 32,
  parameter int TMO_W  = 8,
  parameter int PM_W   = 2 * TMO_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [PM_W-1:0]   pm_q
);

  logic [TMO_W-1:0] u1_tmo;
  logic [TMO_W-1:0] u2_tmo;
  logic             lpm_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      u1_tmo   <= '0;
      u2_tmo   <= '0;
      lpm_flag <= 1'b0;
    end else if (we) begin
      u1_tmo   <= wdata[TMO_W-1:0];
      u2_tmo   <= wdata[2*TMO_W-1:TMO_W];
      lpm_flag <= wdata[2*TMO_W];
    end
  end

  assign pm_q = {lpm_flag, u2_tmo, u1_tmo};

endmodule

// File: rtl/usbp_fsm.sv
module usbp_fsm
  import usbp_pkg::*;
#(
  parameter bit IS_USB3 = 1'b1,
  parameter bit PWR_RST = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  swreq_t wreq,
  input  logic   attach_i,
  input  logic   fault_i,
  input  logic   rst_done_i,
  input  logic   rst_fail_i,
  input  logic   train_ok_i,
  output pst_e   st_q,
  output logic   pwr_q,
  output logic   conn_q,
  output logic   csc_q,
  output logic   ped,
  output logic   prst
);

  pst_e nxt;
  pst_e attach_st;
  logic lt_done;
  logic rxdet_req;

  generate
    if (IS_USB3) begin : g_ss
      assign attach_st = PS_POLL;
      assign lt_done   = train_ok_i;
      assign rxdet_req = wreq.ls_we && (wreq.ls_val == LS_RXDET);
    end else begin : g_hs
      assign attach_st = PS_DIS;
      assign lt_done   = 1'b0;
      assign rxdet_req = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q  <= PWR_RST;
      conn_q <= 1'b0;
      csc_q  <= 1'b0;
    end else begin
      if (wreq.pwr_we) pwr_q <= wreq.pwr_val;
      conn_q <= attach_i;
      if (attach_i != conn_q) csc_q <= 1'b1;
      else if (wreq.csc_clr)  csc_q <= 1'b0;
    end
  end

  always_comb begin
    nxt = st_q;
    if (!pwr_q || !conn_q) begin
      nxt = PS_DISC;
    end else if (st_q != PS_DISC && fault_i) begin
      nxt = PS_DIS;
    end else if (st_q != PS_DISC && wreq.rst_req) begin
      nxt = PS_RST;
    end else begin
      case (st_q)
        PS_DISC: nxt = attach_st;
        PS_POLL: if (lt_done) nxt = PS_EN;
        PS_EN:   if (wreq.dis_req) nxt = PS_DIS;
        PS_DIS:  if (rxdet_req) nxt = PS_DISC;
        PS_RST: begin
          if (rst_done_i)      nxt = PS_EN;
          else if (rst_fail_i) nxt = PS_DIS;
        end
        default: nxt = PS_DISC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= PS_DISC;
    else     st_q <= nxt;
  end

  assign ped  = pwr_q && (st_q == PS_EN);
  assign prst = pwr_q && (st_q == PS_RST);

endmodule

// File: rtl/usb_port_ctl.sv
module usb_port_ctl
  import usbp_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int TMO_W   = 8,
  parameter bit IS_USB3 = 1'b1,
  parameter bit PWR_RST = 1'b0,
  parameter int ST_OFS  = 0,
  parameter int PM_OFS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              attach_i,
  input  logic              fault_i,
  input  logic              rst_done_i,
  input  logic              rst_fail_i,
  input  logic              train_ok_i
);

  localparam int PM_W = 2 * TMO_W + 1;

  swreq_t          wreq;
  logic            pm_we;
  logic [PM_W-1:0] pm_q;
  pst_e            st_q;
  logic            pwr_q;
  logic            conn_q;
  logic            csc_q;
  logic            ped;
  logic            prst;
  logic            ccs;

  assign ccs = conn_q && pwr_q;

  usbp_regif #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PM_W   (PM_W),
    .ST_OFS (ST_OFS),
    .PM_OFS (PM_OFS)
  ) u_regif (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .wreq       (wreq),
    .pm_we      (pm_we),
    .pm_q       (pm_q),
    .ccs        (ccs),
    .ped        (ped),
    .prst       (prst),
    .st         (st_q),
    .pwr        (pwr_q),
    .csc        (csc_q)
  );

  usbp_pmw #(
    .DATA_W (DATA_W),
    .TMO_W  (TMO_W),
    .PM_W   (PM_W)
  ) u_pmw (
    .clk   (clk),
    .rst   (rst),
    .we    (pm_we),
    .wdata (bus_wdata),
    .pm_q  (pm_q)
  );

  usbp_fsm #(
    .IS_USB3 (IS_USB3),
    .PWR_RST (PWR_RST)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wreq       (wreq),
    .attach_i   (attach_i),
    .fault_i    (fault_i),
    .rst_done_i (rst_done_i),
    .rst_fail_i (rst_fail_i),
    .train_ok_i (train_ok_i),
    .st_q       (st_q),
    .pwr_q      (pwr_q),
    .conn_q     (conn_q),
    .csc_q      (csc_q),
    .ped        (ped),
    .prst       (prst)
  );

endmodule

// File: rtl/usbp_chk.sv
module usbp_chk
  import usbp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                     clk,
  input logic                     rst,
  input pst_e                     st_q,
  input logic                     pwr_q,
  input logic                     conn_q,
  input logic                     csc_q,
  input logic                     ped,
  input logic                     prst,
  input logic                     rst_req,
  input logic                     attach_i,
  input logic                     fault_i,
  input logic                     rst_done_i,
  input logic                     bus_rvalid,
  input logic [DATA_W-ST_TOP-1:0] rd_hi
);

  p_enable_src_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ped) |-> ($past(st_q) == PS_RST || $past(st_q) == PS_POLL));

  p_fault_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (ped && fault_i) |=> !ped);

  p_detach_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (ped && !conn_q) |=> !ped);

  p_reset_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (pwr_q && conn_q && st_q != PS_DISC && !fault_i && rst_req) |=> prst);

  p_reset_done_r5: assert property (@(posedge clk) disable iff (rst)
    (prst && conn_q && !fault_i && !rst_req && rst_done_i && pwr_q && !rst) |=> ped);

  p_power_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!pwr_q && $past(!pwr_q)) |-> (st_q == PS_DISC));

  p_hi_zero_r10: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> (rd_hi == '0));

  p_csc_set_r12: assert property (@(posedge clk) disable iff (rst)
    (attach_i != conn_q) |=> csc_q);

endmodule

bind usb_port_ctl usbp_chk #(
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .st_q       (st_q),
  .pwr_q      (pwr_q),
  .conn_q     (conn_q),
  .csc_q      (csc_q),
  .ped        (ped),
  .prst       (prst),
  .rst_req    (wreq.rst_req),
  .attach_i   (attach_i),
  .fault_i    (fault_i),
  .rst_done_i (rst_done_i),
  .bus_rvalid (bus_rvalid),
  .rd_hi      (bus_rdata[DATA_W-1:usbp_pkg::ST_TOP])
);

// File: tb/tb_usb_port_ctl.sv
`timescale 1ns/1ps
module tb_usb_port_ctl;

  localparam logic [3:0]  A_ST  = 4'h0;
  localparam logic [3:0]  A_PM  = 4'h4;
  localparam logic [31:0] PWR   = 32'h0000_0200;
  localparam logic [31:0] PED   = 32'h0000_0002;
  localparam logic [31:0] PR    = 32'h0000_0010;
  localparam logic [31:0] LWS   = 32'h0001_0000;
  localparam logic [31:0] CSC   = 32'h0002_0000;
  localparam logic [31:0] LS5   = 32'h0000_00A0;
  localparam logic [31:0] M_ALL = 32'hFFFF_FFFF;
  localparam logic [31:0] M_NC  = 32'hFFFD_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we3 = 0, we2 = 0, re3 = 0, re2 = 0;
  logic        at3 = 0, at2 = 0, flt3 = 0, flt2 = 0;
  logic        dn3 = 0, dn2 = 0, fl3 = 0, fl2 = 0, tr3 = 0, tr2 = 0;
  logic [31:0] rd3, rd2;
  logic        rv3, rv2;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  typedef struct {
    int          d;
    logic [31:0] exp;
    logic [31:0] m;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  usb_port_ctl #(.IS_USB3(1'b1)) dut (
    .clk(clk), .rst(rst), .bus_wr(we3), .bus_rd(re3), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd3), .bus_rvalid(rv3), .attach_i(at3),
    .fault_i(flt3), .rst_done_i(dn3), .rst_fail_i(fl3), .train_ok_i(tr3));

  usb_port_ctl #(.IS_USB3(1'b0)) dut_u2 (
    .clk(clk), .rst(rst), .bus_wr(we2), .bus_rd(re2), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd2), .bus_rvalid(rv2), .attach_i(at2),
    .fault_i(flt2), .rst_done_i(dn2), .rst_fail_i(fl2), .train_ok_i(tr2));

  function automatic logic [31:0] sw(bit c, bit e, bit r, logic [3:0] ls, bit p, bit s);
    logic [31:0] v;
    v = '0;
    v[0] = c; v[1] = e; v[4] = r; v[8:5] = ls; v[9] = p; v[17] = s;
    return v;
  endfunction

  // monitor: pops the scoreboard whenever a read returns
  always @(negedge clk) begin
    if (rv3 || rv2) begin
      item_t it;
      logic [31:0] got;
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read return got=%h exp=none", rv3 ? rd3 : rd2);
      end else begin
        it  = q.pop_front();
        got = (it.d == 0) ? rd3 : rd2;
        if (((it.d == 0) ? !rv3 : !rv2) || ((got & it.m) != (it.exp & it.m))) begin
          bad++;
          $display("FAIL %s dut%0d got=%h exp=%h", it.tag, it.d, got & it.m, it.exp & it.m);
        end
      end
    end
  end

  task automatic wr(int d, logic [3:0] a, logic [31:0] v);
    @(negedge clk);
    addr = a; wdata = v;
    if (d == 0) we3 = 1'b1; else we2 = 1'b1;
    @(negedge clk);
    we3 = 1'b0; we2 = 1'b0;
  endtask

  task automatic rd(int d, logic [3:0] a, logic [31:0] exp, logic [31:0] m, string tag);
    item_t it;
    @(negedge clk);
    it.d = d; it.exp = exp; it.m = m; it.tag = tag;
    q.push_back(it);
    addr = a;
    if (d == 0) re3 = 1'b1; else re2 = 1'b1;
    @(negedge clk);
    re3 = 1'b0; re2 = 1'b0;
  endtask

  // which: 0 fault, 1 reset done, 2 reset failed, 3 training done
  task automatic pulse(int d, int which);
    @(negedge clk);
    case (which)
      0: if (d == 0) flt3 = 1'b1; else flt2 = 1'b1;
      1: if (d == 0) dn3  = 1'b1; else dn2  = 1'b1;
      2: if (d == 0) fl3  = 1'b1; else fl2  = 1'b1;
      default: if (d == 0) tr3 = 1'b1; else tr2 = 1'b1;
    endcase
    @(negedge clk);
    flt3 = 0; flt2 = 0; dn3 = 0; dn2 = 0; fl3 = 0; fl2 = 0; tr3 = 0; tr2 = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(0, A_ST, 32'h0000_00A0, M_ALL, "R1 status after reset");
    rd(1, A_ST, 32'h0000_00A0, M_ALL, "R1 status after reset");
    rd(0, A_PM, 32'h0, M_ALL, "R1 pm after reset");

    // power on, attach both
    wr(0, A_ST, PWR);
    wr(1, A_ST, PWR);
    @(negedge clk); at3 = 1'b1; at2 = 1'b1;
    idle(3);
    rd(0, A_ST, sw(1,0,0,4'd7,1,1), M_ALL, "R7 attach to polling, R12 change flag");
    rd(1, A_ST, sw(1,0,0,4'd4,1,1), M_ALL, "R6 attach to disabled, R12 change flag");

    // R12 sticky clear
    wr(0, A_ST, PWR);
    rd(0, A_ST, sw(1,0,0,4'd7,1,1), M_ALL, "R12 write 0 keeps flag");
    wr(0, A_ST, PWR | CSC);
    rd(0, A_ST, sw(1,0,0,4'd7,1,0), M_ALL, "R12 write 1 clears flag");
    wr(1, A_ST, PWR | CSC);
    rd(1, A_ST, sw(1,0,0,4'd4,1,0), M_ALL, "R12 write 1 clears flag");

    // R6 USB2 path
    pulse(1, 3);
    rd(1, A_ST, sw(1,0,0,4'd4,1,0), M_ALL, "R6 training ignored");
    wr(1, A_ST, PWR | LWS | LS5);
    rd(1, A_ST, sw(1,0,0,4'd4,1,0), M_ALL, "R6 link write ignored");
    wr(1, A_ST, PWR | PR);
    rd(1, A_ST, sw(1,0,1,4'd3,1,0), M_ALL, "R5 reset entry");
    pulse(1, 1);
    rd(1, A_ST, sw(1,1,0,4'd0,1,0), M_ALL, "R5 R6 reset done enables");

    // R7 USB3 training
    pulse(0, 3);
    rd(0, A_ST, sw(1,1,0,4'd0,1,0), M_ALL, "R7 training enables");

    // R2 disable by software
    wr(0, A_ST, PWR);
    rd(0, A_ST, sw(1,1,0,4'd0,1,0), M_ALL, "R2 write 0 no effect");
    wr(0, A_ST, PWR | PED);
    rd(0, A_ST, sw(1,0,0,4'd4,1,0), M_ALL, "R2 write 1 disables");

    // R3 software cannot enable
    wr(0, A_ST, PWR | PED);
    rd(0, A_ST, sw(1,0,0,4'd4,1,0), M_ALL, "R3 write 1 does not enable");

    // R8 escape from disabled
    pulse(0, 3);
    rd(0, A_ST, sw(1,0,0,4'd4,1,0), M_ALL, "R8 training ignored in disabled");
    wr(0, A_ST, PWR | LWS | LS5);
    rd(0, A_ST, sw(1,0,0,4'd7,1,0), M_ALL, "R8 link 5 back to polling");
    pulse(0, 3);
    rd(0, A_ST, sw(1,1,0,4'd0,1,0), M_ALL, "R8 retrain enables");

    // R11 reset wins over disable
    wr(0, A_ST, PWR | PED | PR);
    rd(0, A_ST, sw(1,0,1,4'd3,1,0), M_ALL, "R11 reset priority");
    pulse(0, 1);
    rd(0, A_ST, sw(1,1,0,4'd0,1,0), M_ALL, "R11 enabled after reset");

    // R5 failed reset
    wr(0, A_ST, PWR | PR);
    pulse(0, 2);
    rd(0, A_ST, sw(1,0,0,4'd4,1,0), M_ALL, "R5 reset failed");

    // R4 fault and detach
    pulse(1, 0);
    rd(1, A_ST, sw(1,0,0,4'd4,1,0), M_ALL, "R4 fault clears enable");
    wr(0, A_ST, PWR | PR);
    pulse(0, 1);
    rd(0, A_ST, sw(1,1,0,4'd0,1,0), M_ALL, "R5 reset done");
    @(negedge clk); at3 = 1'b0;
    idle(3);
    rd(0, A_ST, sw(0,0,0,4'd5,1,1), M_ALL, "R4 detach clears enable");

    // R9 power off
    wr(1, A_ST, PWR | PR);
    pulse(1, 1);
    rd(1, A_ST, sw(1,1,0,4'd0,1,0), M_ALL, "R5 reset done");
    wr(1, A_ST, 32'h0);
    idle(1);
    rd(1, A_ST, sw(0,0,0,4'd5,0,0), M_NC, "R9 power off masks flags");

    // R10 power-management word
    wr(0, A_PM, 32'hFFFF_FFFF);
    rd(0, A_PM, 32'h0001_FFFF, M_ALL, "R10 upper bits read zero");
    wr(0, A_PM, 32'h0001_A55A);
    rd(0, A_PM, 32'h0001_A55A, M_ALL, "R10 pattern");
    wr(0, A_PM, 32'h0000_3C00);
    rd(0, A_PM, 32'h0000_3C00, M_ALL, "R10 flag cleared");
    rd(0, A_ST, sw(0,0,0,4'd5,1,1), M_ALL, "R10 status untouched by pm write");
    rd(1, A_PM, 32'h0, M_ALL, "R10 other port pm unchanged");

    idle(4);
    if (q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard left=%0d exp=0", q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule